// File: doc/BRIEF.md
# Two-Pass Memory Image Binarizer

This engine sits on one word-wide memory port and turns a greyscale image held in memory into a two-level image. The memory is split into four quadrants. The top two address bits select the quadrant and the remaining bits select one of 256K 32-bit words. Every word holds four 8-bit pixels. The source image lives in quadrant 0. The two-level copy goes to quadrant 2, and the intensity statistics go to quadrant 3.

In automatic mode the engine reads the whole image once and sorts every pixel into one of eight intensity bins. From the two most populated bins it derives a cut level. It then writes the bin totals and the cut level to the statistics quadrant, reads the image a second time, and writes the binarized words. A second read is needed because the cut level is only known once the histogram is complete. In manual mode the cut level comes from an input pin. The image is read once, and each read is followed by the matching result write.

The memory side uses a request/acknowledge handshake with one access outstanding. The engine holds the address, the direction and the write data steady until the acknowledge arrives. A start pulse loads the configuration. A busy flag and a one-cycle done pulse report progress.

Top module: `img_binarizer`

## Requirements
- R1: While reset is asserted and whenever no job is running, `busy_o`, `done_o` and `mem_req_o` are low. An asynchronous reset in the middle of a job drops them at once.
- R2: In automatic mode the engine reads quadrant 0 offsets 0 to len-1 in ascending order, twice. Each read is a request with `mem_we_o` low. The address, direction and write data stay stable until `mem_ack_i` is seen.
- R3: Each pixel counts into bin number pixel[7:5]. All four pixels of every word are counted. Once the first read pass has ended, the eight totals are written, zero-extended, to quadrant 3 offsets 0 to 7 in ascending order. This happens once, and before any result write.
- R4: The automatic cut level is 16*(a+b)+16. Here a is the bin with the largest total, and b is the bin with the largest total among the rest, with the lowest index winning any tie. The cut level is written to quadrant 3 offset 8 in bits 7:0, with the upper bits zero.
- R5: Result word k is written to quadrant 2 offset k. Each byte lane (bits 31:24, 23:16, 15:8, 7:0) becomes FF when its source pixel in the same lane is strictly greater than the cut level, and 00 otherwise. In automatic mode each result write follows the second-pass read of the same word.
- R6: In manual mode the cut level is `man_thresh_i` as sampled at start. For each k in ascending order there is one read of quadrant 0 offset k followed by the write of quadrant 2 offset k. Nothing is written to quadrant 3.
- R7: `busy_o` rises in the cycle after a start is accepted. One cycle after the acknowledge of the last result write, `busy_o` is low and `done_o` is high for exactly one cycle. The engine then stays idle with no requests.
- R8: While busy, a start pulse and any change of `auto_mode_i`, `man_thresh_i` or `img_words_i` have no effect on the running job. The length must be at least 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, honoured only when idle |
| auto_mode_i | input | 1 | 1: automatic two-pass mode, 0: manual single pass |
| man_thresh_i | input | 8 | Cut level used in manual mode |
| img_words_i | input | ADDR_W+1 | Image length in words (at least 1) |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | 1 for a write, 0 for a read |
| mem_addr_o | output | ADDR_W+2 | Quadrant (top 2 bits) and word offset |
| mem_wdata_o | output | 32 | Write data |
| mem_ack_i | input | 1 | Access acknowledge, read data valid with it |
| mem_rdata_i | input | 32 | Read data |
| busy_o | output | 1 | Job in progress |
| done_o | output | 1 | One-cycle end-of-job pulse |

## Verification
`busy_o` is due one cycle after the edge that samples start, and the bench checks it at the next falling edge. Memory accesses complete at whatever cycle the modelled memory acknowledges them, so the bench logs each access at its acknowledge edge. It then compares the order, the addresses and the write data against a sequence it builds from the requirements, and it does not count absolute cycles. The done pulse is due one cycle after the final result acknowledge. A falling-edge monitor checks that the sample just before each done pulse showed that acknowledge, and that busy is already low during the pulse.

// File: rtl/bin_pkg.sv
package bin_pkg;
  localparam int PIX_W     = 8;
  localparam int LANES     = 4;
  localparam int WORD_W    = LANES * PIX_W;
  localparam int NBINS     = 8;
  localparam int BIN_SEL_W = $clog2(NBINS);
  localparam int INC_W     = $clog2(LANES + 1);

  localparam logic [1:0] Q_SRC  = 2'd0;
  localparam logic [1:0] Q_DST  = 2'd2;
  localparam logic [1:0] Q_STAT = 2'd3;

  typedef enum logic [2:0] {
    S_IDLE,
    S_HREAD,
    S_STAT,
    S_BREAD,
    S_BWRITE
  } state_t;
endpackage

// File: rtl/rst_sync.sv
module rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/bin_hist.sv
module bin_hist import bin_pkg::*; #(
  parameter int CNT_W = 21
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             clr_i,
  input  logic                             en_i,
  input  logic [WORD_W-1:0]                word_i,
  output logic [NBINS-1:0][CNT_W-1:0]      counts_o,
  output logic [PIX_W-1:0]                 thr_o
);
  localparam int HALF_SPAN = (1 << (PIX_W - BIN_SEL_W)) / 2;

  logic [NBINS-1:0][INC_W-1:0] inc;

  for (genvar b = 0; b < NBINS; b++) begin : g_bin
    always_comb begin
      inc[b] = '0;
      for (int l = 0; l < LANES; l++) begin
        if (word_i[l*PIX_W + PIX_W - BIN_SEL_W +: BIN_SEL_W] == BIN_SEL_W'(b))
          inc[b] = inc[b] + INC_W'(1);
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     counts_o[b] <= '0;
      else if (clr_i) counts_o[b] <= '0;
      else if (en_i)  counts_o[b] <= counts_o[b] + CNT_W'(inc[b]);
    end
  end

  logic [BIN_SEL_W-1:0] pk_a, pk_b;
  logic [BIN_SEL_W:0]   pk_sum;

  always_comb begin
    pk_a = '0;
    for (int i = 1; i < NBINS; i++)
      if (counts_o[i] > counts_o[pk_a]) pk_a = BIN_SEL_W'(i);
    pk_b = (pk_a == '0) ? BIN_SEL_W'(1) : '0;
    for (int i = 0; i < NBINS; i++)
      if ((BIN_SEL_W'(i) != pk_a) && (counts_o[i] > counts_o[pk_b])) pk_b = BIN_SEL_W'(i);
    pk_sum = {1'b0, pk_a} + {1'b0, pk_b};
    thr_o  = PIX_W'(int'(pk_sum) * HALF_SPAN + HALF_SPAN);
  end
endmodule

// File: rtl/word_binarize.sv
module word_binarize import bin_pkg::*; (
  input  logic [WORD_W-1:0] word_i,
  input  logic [PIX_W-1:0]  thr_i,
  output logic [WORD_W-1:0] word_o
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign word_o[l*PIX_W +: PIX_W] =
      (word_i[l*PIX_W +: PIX_W] > thr_i) ? {PIX_W{1'b1}} : {PIX_W{1'b0}};
  end
endmodule

// File: rtl/img_binarizer.sv
module img_binarizer import bin_pkg::*; #(
  parameter int ADDR_W = 18
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic                auto_mode_i,
  input  logic [PIX_W-1:0]    man_thresh_i,
  input  logic [ADDR_W:0]     img_words_i,
  output logic                mem_req_o,
  output logic                mem_we_o,
  output logic [ADDR_W+1:0]   mem_addr_o,
  output logic [WORD_W-1:0]   mem_wdata_o,
  input  logic                mem_ack_i,
  input  logic [WORD_W-1:0]   mem_rdata_i,
  output logic                busy_o,
  output logic                done_o
);
  localparam int LEN_W = ADDR_W + 1;
  localparam int CNT_W = ADDR_W + 3;

  logic                          rst_s;
  state_t                        st_q, st_d;
  logic [LEN_W-1:0]              idx_q, idx_d, len_q, len_m1;
  logic                          done_q, done_d;
  logic [PIX_W-1:0]              thr_q, thr_d, auto_thr;
  logic [WORD_W-1:0]             word_q, bin_word, wdata;
  logic [1:0]                    quad;
  logic                          cfg_en, thr_en, word_en, hist_clr, hist_en;
  logic [NBINS-1:0][CNT_W-1:0]   counts;

  rst_sync u_rst (.clk(clk), .arst_n(rst_n), .rst_n_o(rst_s));

  bin_hist #(.CNT_W(CNT_W)) u_hist (
    .clk(clk), .rst_n(rst_s), .clr_i(hist_clr), .en_i(hist_en),
    .word_i(mem_rdata_i), .counts_o(counts), .thr_o(auto_thr)
  );

  word_binarize u_bin (.word_i(word_q), .thr_i(thr_q), .word_o(bin_word));

  assign len_m1 = len_q - LEN_W'(1);

  // next-state logic
  always_comb begin
    st_d     = st_q;
    idx_d    = idx_q;
    done_d   = 1'b0;
    cfg_en   = 1'b0;
    thr_en   = 1'b0;
    thr_d    = auto_thr;
    hist_clr = 1'b0;
    hist_en  = 1'b0;
    word_en  = 1'b0;
    unique case (st_q)
      S_IDLE: if (start_i) begin
        cfg_en   = 1'b1;
        hist_clr = 1'b1;
        idx_d    = '0;
        if (auto_mode_i) st_d = S_HREAD;
        else begin
          thr_en = 1'b1;
          thr_d  = man_thresh_i;
          st_d   = S_BREAD;
        end
      end
      S_HREAD: if (mem_ack_i) begin
        hist_en = 1'b1;
        if (idx_q == len_m1) begin
          idx_d = '0;
          st_d  = S_STAT;
        end else idx_d = idx_q + LEN_W'(1);
      end
      S_STAT: if (mem_ack_i) begin
        if (idx_q == LEN_W'(NBINS)) begin
          idx_d  = '0;
          thr_en = 1'b1;
          st_d   = S_BREAD;
        end else idx_d = idx_q + LEN_W'(1);
      end
      S_BREAD: if (mem_ack_i) begin
        word_en = 1'b1;
        st_d    = S_BWRITE;
      end
      S_BWRITE: if (mem_ack_i) begin
        if (idx_q == len_m1) begin
          done_d = 1'b1;
          st_d   = S_IDLE;
        end else begin
          idx_d = idx_q + LEN_W'(1);
          st_d  = S_BREAD;
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  // control registers
  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      st_q   <= S_IDLE;
      idx_q  <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      idx_q  <= idx_d;
      done_q <= done_d;
    end
  end

  // datapath registers with explicit enables
  always_ff @(posedge clk) begin
    if (cfg_en) len_q  <= img_words_i;
    if (thr_en) thr_q  <= thr_d;
    if (word_en) word_q <= mem_rdata_i;
  end

  // memory port drive
  always_comb begin
    quad  = Q_SRC;
    wdata = '0;
    case (st_q)
      S_STAT: begin
        quad  = Q_STAT;
        wdata = (idx_q < LEN_W'(NBINS)) ? WORD_W'(counts[idx_q[BIN_SEL_W-1:0]])
                                         : WORD_W'(auto_thr);
      end
      S_BWRITE: begin
        quad  = Q_DST;
        wdata = bin_word;
      end
      default: ;
    endcase
  end

  assign mem_req_o   = (st_q != S_IDLE);
  assign mem_we_o    = (st_q == S_STAT) || (st_q == S_BWRITE);
  assign mem_addr_o  = {quad, idx_q[ADDR_W-1:0]};
  assign mem_wdata_o = wdata;
  assign busy_o      = (st_q != S_IDLE);
  assign done_o      = done_q;
endmodule

// File: rtl/img_binarizer_chk.sv
module img_binarizer_chk #(
  parameter int ADDR_W = 18
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [ADDR_W+1:0] mem_addr_o,
  input logic [31:0]       mem_wdata_o,
  input logic              mem_ack_i,
  input logic              busy_o,
  input logic              done_o
);
  logic [1:0] quad;
  assign quad = mem_addr_o[ADDR_W+1:ADDR_W];

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !mem_req_o);

  p_hold_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) &&
                                   $stable(mem_we_o) && $stable(mem_wdata_o)));

  p_read_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_we_o) |-> (quad == 2'd0));

  p_write_quad_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && mem_we_o) |-> (quad == 2'd2 || quad == 2'd3));

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);
endmodule

bind img_binarizer img_binarizer_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
  .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_ack_i(mem_ack_i),
  .busy_o(busy_o), .done_o(done_o)
);

// File: tb/img_binarizer_tb.sv
`timescale 1ns/1ps
module img_binarizer_tb;
  localparam int AW    = 18;
  localparam int LEN_W = AW + 1;
  localparam int MW    = AW + 2;
  localparam int LOGN  = 1024;

  typedef struct packed {
    logic       auto_m;
    logic [7:0] thr;
    logic [7:0] len;
    logic [3:0] lat;
    logic [1:0] pat;   // 0 hash, 1 constant pa, 2 alternating pa/pb
    logic [7:0] pa;
    logic [7:0] pb;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VEC [NVEC] = '{
    '{1'b1, 8'h00, 8'd8,  4'd0, 2'd0, 8'd1,   8'd0},    // auto, mixed pixels
    '{1'b1, 8'h00, 8'd4,  4'd1, 2'd1, 8'hE0,  8'd0},    // auto, one bin only -> cut 128
    '{1'b1, 8'h00, 8'd10, 4'd2, 2'd2, 8'h20,  8'hC8},   // auto, bins 1 and 6 -> cut 128
    '{1'b1, 8'h00, 8'd1,  4'd3, 2'd0, 8'd2,   8'd0},    // auto, single word
    '{1'b0, 8'h80, 8'd5,  4'd0, 2'd2, 8'h80,  8'h81},   // manual, equal pixel gives 00
    '{1'b0, 8'hFF, 8'd7,  4'd1, 2'd0, 8'd3,   8'd0},    // manual, top cut -> all 00
    '{1'b0, 8'h00, 8'd3,  4'd2, 2'd2, 8'h00,  8'h01},   // manual, zero cut
    '{1'b1, 8'h00, 8'd16, 4'd1, 2'd2, 8'h10,  8'h30}    // auto, bins 0 and 1 -> cut 32
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic             start = 1'b0, auto_m = 1'b0;
  logic [7:0]       mthr = 8'h00;
  logic [LEN_W-1:0] nwords = '0;
  logic             req, we, ack, busy, done;
  logic [MW-1:0]    addr;
  logic [31:0]      wdata, rdata;

  img_binarizer #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .auto_mode_i(auto_m),
    .man_thresh_i(mthr), .img_words_i(nwords), .mem_req_o(req), .mem_we_o(we),
    .mem_addr_o(addr), .mem_wdata_o(wdata), .mem_ack_i(ack), .mem_rdata_i(rdata),
    .busy_o(busy), .done_o(done)
  );

  // memory model: quadrant 0 image, access log in acknowledge order
  logic [31:0]   q0 [64];
  int            lat = 0;
  int            wcnt = 0;
  int            lg_n = 0;
  logic [MW-1:0] lg_addr [LOGN];
  logic          lg_we   [LOGN];
  logic [31:0]   lg_data [LOGN];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack  <= 1'b0;
      wcnt <= 0;
    end else begin
      ack <= 1'b0;
      if (req && !ack) begin
        if (wcnt >= lat) begin
          ack  <= 1'b1;
          wcnt <= 0;
          rdata <= (addr[MW-1:AW] == 2'd0 && addr[AW-1:0] < 64) ? q0[addr[5:0]] : 32'h0;
          lg_addr[lg_n % LOGN] <= addr;
          lg_we[lg_n % LOGN]   <= we;
          lg_data[lg_n % LOGN] <= wdata;
          lg_n <= lg_n + 1;
        end else wcnt <= wcnt + 1;
      end
    end
  end

  // done monitor
  int   done_cnt = 0, done_bad = 0, cur_len = 1;
  logic pv_fin = 1'b0;
  always @(negedge clk) begin
    if (done) begin
      done_cnt = done_cnt + 1;
      if (!pv_fin || busy) done_bad = done_bad + 1;
    end
    pv_fin = ack && we && (addr[MW-1:AW] == 2'd2) && (int'(addr[AW-1:0]) == cur_len - 1);
  end

  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  function automatic logic [7:0] pix(input vec_t v, input int k, input int l);
    case (v.pat)
      2'd0:    return 8'(int'(v.pa) * 37 + k * 53 + l * 101 + k * l * 7);
      2'd1:    return v.pa;
      default: return (((k + l) % 2) == 1) ? v.pb : v.pa;
    endcase
  endfunction

  function automatic logic [MW-1:0] mk(input logic [1:0] q, input int off);
    return {q, AW'(off)};
  endfunction

  task automatic run_vec(input vec_t v, input string nm, input bit disturb);
    int cnt [8];
    int a, b, mx, e_n, base, dbase, dbad, t;
    logic [7:0] th;
    logic [MW-1:0] e_addr [64];
    logic          e_we   [64];
    logic [31:0]   e_data [64];
    bit ok_rd, ok_bin, ok_thr, ok_res;
    logic [31:0] rw;

    for (int i = 0; i < 8; i++) cnt[i] = 0;
    for (int k = 0; k < 64; k++) q0[k] = 32'h0;
    for (int k = 0; k < int'(v.len); k++) begin
      for (int l = 0; l < 4; l++) begin
        q0[k][l*8 +: 8] = pix(v, k, l);
        cnt[pix(v, k, l) / 32]++;
      end
    end
    // reference cut level: largest bin, then largest remaining, lowest index on ties
    mx = -1; a = 0;
    for (int i = 0; i < 8; i++) if (cnt[i] > mx) begin mx = cnt[i]; a = i; end
    mx = -1; b = 0;
    for (int i = 0; i < 8; i++) if (i != a && cnt[i] > mx) begin mx = cnt[i]; b = i; end
    th = v.auto_m ? 8'(16 * (a + b) + 16) : v.thr;

    e_n = 0;
    if (v.auto_m) begin
      for (int k = 0; k < int'(v.len); k++) begin
        e_addr[e_n] = mk(2'd0, k); e_we[e_n] = 1'b0; e_data[e_n] = '0; e_n++;
      end
      for (int j = 0; j < 8; j++) begin
        e_addr[e_n] = mk(2'd3, j); e_we[e_n] = 1'b1; e_data[e_n] = 32'(cnt[j]); e_n++;
      end
      e_addr[e_n] = mk(2'd3, 8); e_we[e_n] = 1'b1; e_data[e_n] = {24'h0, th}; e_n++;
    end
    for (int k = 0; k < int'(v.len); k++) begin
      for (int l = 0; l < 4; l++) rw[l*8 +: 8] = (q0[k][l*8 +: 8] > th) ? 8'hFF : 8'h00;
      e_addr[e_n] = mk(2'd0, k); e_we[e_n] = 1'b0; e_data[e_n] = '0; e_n++;
      e_addr[e_n] = mk(2'd2, k); e_we[e_n] = 1'b1; e_data[e_n] = rw;  e_n++;
    end

    @(negedge clk);
    auto_m  = v.auto_m;
    mthr    = v.thr;
    nwords  = LEN_W'(v.len);
    lat     = int'(v.lat);
    cur_len = int'(v.len);
    base    = lg_n;
    dbase   = done_cnt;
    dbad    = done_bad;
    start   = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R7", {nm, " busy one cycle after start"}, busy, 1);

    t = 0;
    while (done_cnt == dbase && t < 5000) begin
      @(negedge clk);
      t++;
      if (disturb && t == 10) begin
        start = 1'b1; auto_m = ~v.auto_m; mthr = ~v.thr; nwords = LEN_W'(2);
      end
      if (disturb && t == 11) start = 1'b0;
    end
    repeat (3) @(negedge clk);

    chk(done_cnt - dbase == 1, "R7", {nm, " done pulse count"}, done_cnt - dbase, 1);
    chk(done_bad == dbad, "R7", {nm, " done follows last result ack with busy low"},
        done_bad - dbad, 0);
    chk(lg_n - base == e_n, v.auto_m ? "R2" : "R6", {nm, " access count"}, lg_n - base, e_n);

    ok_rd = 1'b1; ok_bin = 1'b1; ok_thr = 1'b1; ok_res = 1'b1;
    for (int i = 0; i < e_n && i < lg_n - base; i++) begin
      int  p;
      bit  bad;
      p   = (base + i) % LOGN;
      bad = (lg_addr[p] != e_addr[i]) || (lg_we[p] != e_we[i]) ||
            (e_we[i] && lg_data[p] != e_data[i]);
      if (bad) begin
        if (!e_we[i]) begin
          if (ok_rd) $display("  entry %0d addr=%0h we=%0b", i, lg_addr[p], lg_we[p]);
          ok_rd = 1'b0;
        end else if (e_addr[i][MW-1:AW] == 2'd3 && i < e_n && e_addr[i][AW-1:0] == 8) begin
          ok_thr = 1'b0;
        end else if (e_addr[i][MW-1:AW] == 2'd3) begin
          ok_bin = 1'b0;
        end else begin
          if (ok_res) $display("  entry %0d addr=%0h data=%0h exp=%0h", i, lg_addr[p],
                               lg_data[p], e_data[i]);
          ok_res = 1'b0;
        end
      end
    end
    chk(ok_rd, v.auto_m ? "R2" : "R6", {nm, " read order"}, ok_rd, 1);
    if (v.auto_m) begin
      chk(ok_bin, "R3", {nm, " bin totals"}, ok_bin, 1);
      chk(ok_thr, "R4", {nm, " cut level word"}, ok_thr, 1);
    end
    chk(ok_res, v.auto_m ? "R5" : "R6", {nm, " result words"}, ok_res, 1);
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R7 watchdog expired: actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !req, "R1", "outputs in reset", {busy, done, req}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(!busy && !done && !req, "R1", "idle after reset", {busy, done, req}, 0);

    for (int i = 0; i < NVEC; i++) run_vec(VEC[i], $sformatf("vec%0d", i), 1'b0);

    // R8: start pulse and config changes while busy are ignored
    run_vec('{1'b0, 8'h60, 8'd6, 4'd2, 2'd0, 8'd9, 8'd0}, "r8_manual", 1'b1);
    run_vec('{1'b1, 8'h00, 8'd5, 4'd1, 2'd0, 8'd4, 8'd0}, "r8_auto", 1'b1);

    // R7: stays idle afterwards
    base = lg_n;
    repeat (20) @(negedge clk);
    chk(lg_n == base && !req && !busy, "R7", "no activity after done", lg_n - base, 0);

    // R1: reset in the middle of a job
    @(negedge clk);
    auto_m = 1'b1; nwords = LEN_W'(16); lat = 3; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (15) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(!busy && !req && !done, "R1", "mid-job reset clears outputs", {busy, req, done}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(!busy && !req, "R1", "idle after mid-job reset", {busy, req}, 0);
    run_vec(VEC[0], "after_reset", 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule